// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects every reason a small microcontroller can have to restart and turns each one into a single timed system-reset sequence. The causes are power-on, a low driven onto the reset pad from outside, a watchdog timeout, an illegal instruction, an opcode fetch from an unmapped address, and a bus reset request. A STOP instruction counts as an illegal instruction when the stop option is off. A data access to an unmapped address does not reset anything. The CPU decoder, the oscillator and the watchdog counter sit outside the block and reach it only as single-cycle strobes.

After power-on the block holds the chip in reset for a long recovery count. Then come two short phases. In the first, the block pulls the open-drain reset pad low. In the second, the pad is released but the CPU is still held. After that the block steps the reset-vector fetch through two addresses and lets the CPU run. A six-bit sticky status word records which causes have occurred. A combinational gate lets the watchdog be switched off, but only when a high-voltage level is present on a pin.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_i` is high, the pad is driven low, `sys_rst_o` is high and `status_o` equals 6'b000001. After `por_i` falls, the first POR_CYCLES-1 clock edges stay in the power-on hold. Edge POR_CYCLES starts the drive phase. Reset requests that arrive during the hold are ignored.
- R2: The drive phase lasts PHASE_CYCLES cycles with `rst_pin_oe_o` high. The release phase then lasts PHASE_CYCLES cycles with the pad released and `sys_rst_o` still high. Next comes one cycle with `vec_addr_o`=16'hFFFE and one cycle with 16'hFFFF, both with `vec_fetch_o` high and `sys_rst_o` low. The block then runs with all three outputs low.
- R3: An `illegal_op_i` strobe sets status bit 3, and the drive phase restarts at the next edge.
- R4: `stop_exec_i` with `stop_enable_i`=0 acts exactly like R3. With `stop_enable_i`=1 it has no effect on any output.
- R5: `unmapped_i` together with `opcode_fetch_i` sets status bit 4 and restarts the sequence. `unmapped_i` without `opcode_fetch_i` changes neither the status nor the sequence.
- R6: `cop_timeout_i` sets status bit 2 and `bus_reset_i` sets status bit 5. Each also restarts the sequence.
- R7: The pad is sampled only when the block has not driven it in the current cycle or the previous one. A low seen there with no internal cause in the same cycle sets status bit 1 and restarts the sequence. The block's own drive never sets bit 1.
- R8: Status bits are only ever set, and each cause sets only its own bit. Several causes in one cycle set all of their bits. Only power-on (R1) clears the bits, and observing `status_o` clears nothing.
- R9: A request that arrives during the drive, release or vector steps restarts a full drive phase of PHASE_CYCLES cycles, followed by a full release phase. The phases are never shortened.
- R10: `cop_disable_o` = (`monitor_mode_i` & (`hv_rst_i` | `hv_irq_i`)) | (`break_i` & `hv_rst_i`), combinationally.
- R11: Every internal cause, and power-on, drives the pad low for the whole hold and drive phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| rst_pin_i | input | 1 | Level sensed on the reset pad |
| rst_pin_oe_o | output | 1 | High pulls the open-drain reset pad low |
| illegal_op_i | input | 1 | Illegal instruction strobe |
| stop_exec_i | input | 1 | STOP instruction executed strobe |
| stop_enable_i | input | 1 | Option bit: 1 permits STOP |
| unmapped_i | input | 1 | Current access targets an unmapped address |
| opcode_fetch_i | input | 1 | Current access is an opcode fetch |
| cop_timeout_i | input | 1 | Watchdog timeout strobe |
| bus_reset_i | input | 1 | Bus reset request strobe |
| monitor_mode_i | input | 1 | Monitor mode active |
| break_i | input | 1 | Break state active |
| hv_rst_i | input | 1 | High voltage seen on the reset pad |
| hv_irq_i | input | 1 | High voltage seen on the IRQ pad |
| cop_disable_o | output | 1 | Watchdog disable |
| sys_rst_o | output | 1 | Internal system reset to the CPU |
| vec_fetch_o | output | 1 | Reset vector fetch step active |
| vec_addr_o | output | 16 | Vector address during the fetch, else 0 |
| status_o | output | 6 | Sticky causes: 0 power-on, 1 pad, 2 watchdog, 3 illegal opcode, 4 illegal address, 5 bus |

## Verification
Most state errors reach the ports within one cycle. A wrong phase counter or state shows up on `rst_pin_oe_o`, `sys_rst_o` or `vec_fetch_o` on the first cycle it diverges. A sequence that is too short or too long shows up at the phase boundary. A wrong status bit appears on `status_o` right after the edge that took the request. Because status bits are sticky, a bit set by mistake, such as the pad bit during the block's own drive, stays visible for the rest of the run. A restart that fails to reload the counter shows up as an early release up to PHASE_CYCLES cycles later.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int NSRC     = 6;
  localparam int SRC_POR  = 0;
  localparam int SRC_PIN  = 1;
  localparam int SRC_COP  = 2;
  localparam int SRC_ILOP = 3;
  localparam int SRC_ILAD = 4;
  localparam int SRC_BUS  = 5;

  typedef enum logic [2:0] {
    ST_POR, ST_DRIVE, ST_RELEASE, ST_VEC_LO, ST_VEC_HI, ST_RUN
  } seq_state_t;

  // STOP counts as an illegal opcode when the option forbids it
  function automatic logic opcode_trap(logic illegal, logic stop_exec, logic stop_en);
    return illegal | (stop_exec & ~stop_en);
  endfunction

  // an unmapped access only matters on an opcode fetch
  function automatic logic address_trap(logic unmapped, logic opfetch);
    return unmapped & opfetch;
  endfunction

  function automatic logic [15:0] vector_addr(logic [15:0] base, logic second);
    return base | {15'd0, second};
  endfunction
endpackage

// File: rtl/rst_cause_collect.sv
module rst_cause_collect
  import rst_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            por_i,
  input  logic            armed_i,
  input  logic            pin_drive_i,
  input  logic            rst_pin_i,
  input  logic            illegal_op_i,
  input  logic            stop_exec_i,
  input  logic            stop_enable_i,
  input  logic            unmapped_i,
  input  logic            opcode_fetch_i,
  input  logic            cop_timeout_i,
  input  logic            bus_reset_i,
  output logic            req_o,
  output logic [NSRC-1:0] status_o
);
  logic            drive_q;
  logic            internal_hit;
  logic            pin_ext_low;
  logic [NSRC-1:0] hit;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) drive_q <= 1'b1;
    else       drive_q <= pin_drive_i;
  end

  always_comb begin
    hit           = '0;
    hit[SRC_ILOP] = opcode_trap(illegal_op_i, stop_exec_i, stop_enable_i);
    hit[SRC_ILAD] = address_trap(unmapped_i, opcode_fetch_i);
    hit[SRC_COP]  = cop_timeout_i;
    hit[SRC_BUS]  = bus_reset_i;
    internal_hit  = |hit;
    pin_ext_low   = ~rst_pin_i & ~pin_drive_i & ~drive_q;
    hit[SRC_PIN]  = pin_ext_low & ~internal_hit;
  end

  assign req_o = armed_i & (|hit);

  for (genvar i = 0; i < NSRC; i++) begin : g_stat
    localparam logic RST_VAL = (i == SRC_POR);
    always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i)                  status_o[i] <= RST_VAL;
      else if (armed_i && hit[i]) status_o[i] <= 1'b1;
    end
  end

  a_r8_status_sticky: assert property (@(posedge clk_i) disable iff (por_i)
    ((status_o & $past(status_o)) == $past(status_o)));

  a_r7_own_drive_ignored: assert property (@(posedge clk_i) disable iff (por_i)
    pin_drive_i |=> (status_o[SRC_PIN] == $past(status_o[SRC_PIN])));

  a_r5_data_access_quiet: assert property (@(posedge clk_i) disable iff (por_i)
    (unmapped_i && !opcode_fetch_i) |=> (status_o[SRC_ILAD] == $past(status_o[SRC_ILAD])));
endmodule

// File: rtl/rst_phase_seq.sv
module rst_phase_seq
  import rst_seq_pkg::*;
#(
  parameter int          POR_CYCLES   = 4096,
  parameter int          PHASE_CYCLES = 32,
  parameter logic [15:0] VEC_BASE     = 16'hFFFE
) (
  input  logic        clk_i,
  input  logic        por_i,
  input  logic        req_i,
  output logic        armed_o,
  output logic        pin_drive_o,
  output logic        sys_rst_o,
  output logic        vec_fetch_o,
  output logic [15:0] vec_addr_o
);
  localparam int             CNT_W    = $clog2(POR_CYCLES);
  localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0] PH_LAST  = CNT_W'(PHASE_CYCLES - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      state <= ST_POR;
      cnt   <= '0;
    end else if (req_i) begin
      state <= ST_DRIVE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_POR:     if (cnt == POR_LAST) begin state <= ST_DRIVE;   cnt <= '0; end
                    else cnt <= cnt + CNT_W'(1);
        ST_DRIVE:   if (cnt == PH_LAST)  begin state <= ST_RELEASE; cnt <= '0; end
                    else cnt <= cnt + CNT_W'(1);
        ST_RELEASE: if (cnt == PH_LAST)  begin state <= ST_VEC_LO;  cnt <= '0; end
                    else cnt <= cnt + CNT_W'(1);
        ST_VEC_LO:  state <= ST_VEC_HI;
        ST_VEC_HI:  state <= ST_RUN;
        ST_RUN:     state <= ST_RUN;
        default:    state <= ST_POR;
      endcase
    end
  end

  assign armed_o     = (state != ST_POR);
  assign pin_drive_o = (state == ST_POR) || (state == ST_DRIVE);
  assign sys_rst_o   = pin_drive_o || (state == ST_RELEASE);
  assign vec_fetch_o = (state == ST_VEC_LO) || (state == ST_VEC_HI);
  assign vec_addr_o  = vec_fetch_o ? vector_addr(VEC_BASE, state == ST_VEC_HI) : 16'd0;

  a_r9_restart_full: assert property (@(posedge clk_i) disable iff (por_i)
    req_i |=> (state == ST_DRIVE && cnt == '0));

  a_r1_hold_exit: assert property (@(posedge clk_i) disable iff (por_i)
    (state == ST_POR && cnt == POR_LAST) |=> (state == ST_DRIVE));

  a_r2_release_kept: assert property (@(posedge clk_i) disable iff (por_i)
    (state == ST_RELEASE && !req_i && cnt != PH_LAST) |=> (state == ST_RELEASE));

  a_r2_vector_order: assert property (@(posedge clk_i) disable iff (por_i)
    (state == ST_VEC_LO && !req_i) |=> (state == ST_VEC_HI));
endmodule

// File: rtl/cop_gate.sv
module cop_gate (
  input  logic monitor_mode_i,
  input  logic break_i,
  input  logic hv_rst_i,
  input  logic hv_irq_i,
  output logic cop_disable_o
);
  logic mon_path;
  logic brk_path;

  assign mon_path      = monitor_mode_i & (hv_rst_i | hv_irq_i);
  assign brk_path      = break_i & hv_rst_i;
  assign cop_disable_o = mon_path | brk_path;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int POR_CYCLES   = 4096,
  parameter int PHASE_CYCLES = 32
) (
  input  logic        clk_i,
  input  logic        por_i,
  input  logic        rst_pin_i,
  output logic        rst_pin_oe_o,
  input  logic        illegal_op_i,
  input  logic        stop_exec_i,
  input  logic        stop_enable_i,
  input  logic        unmapped_i,
  input  logic        opcode_fetch_i,
  input  logic        cop_timeout_i,
  input  logic        bus_reset_i,
  input  logic        monitor_mode_i,
  input  logic        break_i,
  input  logic        hv_rst_i,
  input  logic        hv_irq_i,
  output logic        cop_disable_o,
  output logic        sys_rst_o,
  output logic        vec_fetch_o,
  output logic [15:0] vec_addr_o,
  output logic [5:0]  status_o
);
  logic reset_req;
  logic armed;
  logic pin_drive;

  rst_cause_collect u_collect (
    .clk_i          (clk_i),
    .por_i          (por_i),
    .armed_i        (armed),
    .pin_drive_i    (pin_drive),
    .rst_pin_i      (rst_pin_i),
    .illegal_op_i   (illegal_op_i),
    .stop_exec_i    (stop_exec_i),
    .stop_enable_i  (stop_enable_i),
    .unmapped_i     (unmapped_i),
    .opcode_fetch_i (opcode_fetch_i),
    .cop_timeout_i  (cop_timeout_i),
    .bus_reset_i    (bus_reset_i),
    .req_o          (reset_req),
    .status_o       (status_o)
  );

  rst_phase_seq #(
    .POR_CYCLES   (POR_CYCLES),
    .PHASE_CYCLES (PHASE_CYCLES),
    .VEC_BASE     (16'hFFFE)
  ) u_seq (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .req_i       (reset_req),
    .armed_o     (armed),
    .pin_drive_o (pin_drive),
    .sys_rst_o   (sys_rst_o),
    .vec_fetch_o (vec_fetch_o),
    .vec_addr_o  (vec_addr_o)
  );

  cop_gate u_cop (
    .monitor_mode_i (monitor_mode_i),
    .break_i        (break_i),
    .hv_rst_i       (hv_rst_i),
    .hv_irq_i       (hv_irq_i),
    .cop_disable_o  (cop_disable_o)
  );

  assign rst_pin_oe_o = pin_drive;

  a_r11_drive_after_request: assert property (@(posedge clk_i) disable iff (por_i)
    reset_req |=> (rst_pin_oe_o && sys_rst_o));

  a_r10_cop_off_outside_modes: assert property (@(posedge clk_i) disable iff (por_i)
    (!monitor_mode_i && !break_i) |-> !cop_disable_o);
endmodule

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;
  localparam int POR = 4096;
  localparam int PH  = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por = 1'b1;
  logic ext_low = 1'b0;
  logic rst_pin, oe;
  logic illegal_op = 0, stop_exec = 0, stop_en = 1, unmapped = 0, opfetch = 0;
  logic cop = 0, bus = 0, mon = 0, brk = 0, hvr = 0, hvi = 0;
  logic cop_dis, sr, vf;
  logic [15:0] addr;
  logic [5:0]  st;

  assign rst_pin = (oe || ext_low) ? 1'b0 : 1'b1;

  rst_seq_ctrl u_rst_seq_ctrl (
    .clk_i(clk), .por_i(por), .rst_pin_i(rst_pin), .rst_pin_oe_o(oe),
    .illegal_op_i(illegal_op), .stop_exec_i(stop_exec), .stop_enable_i(stop_en),
    .unmapped_i(unmapped), .opcode_fetch_i(opfetch), .cop_timeout_i(cop),
    .bus_reset_i(bus), .monitor_mode_i(mon), .break_i(brk), .hv_rst_i(hvr),
    .hv_irq_i(hvi), .cop_disable_o(cop_dis), .sys_rst_o(sr), .vec_fetch_o(vf),
    .vec_addr_o(addr), .status_o(st)
  );

  int checks = 0;
  int errors = 0;
  logic [5:0] exp_st;

  typedef struct packed {
    logic oe; logic sr; logic vf; logic [15:0] addr; logic [5:0] st;
  } exp_t;
  exp_t  q[$];
  string tq[$];

  task automatic push(logic e_oe, logic e_sr, logic e_vf, logic [15:0] e_a, string tag, int n);
    for (int i = 0; i < n; i++) begin
      q.push_back('{e_oe, e_sr, e_vf, e_a, exp_st});
      tq.push_back(tag);
    end
  endtask

  task automatic push_seq(string tag);
    push(1, 1, 0, 16'h0,    tag, PH);
    push(0, 1, 0, 16'h0,    tag, PH);
    push(0, 0, 1, 16'hFFFE, tag, 1);
    push(0, 0, 1, 16'hFFFF, tag, 1);
    push(0, 0, 0, 16'h0,    tag, 3);
  endtask

  // monitor: compare one expected item per cycle
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      checks++;
      if (oe !== e.oe || sr !== e.sr || vf !== e.vf || st !== e.st ||
          (e.vf && addr !== e.addr)) begin
        errors++;
        $display("FAIL %s: oe=%b sr=%b vf=%b addr=%h st=%b expected oe=%b sr=%b vf=%b addr=%h st=%b",
                 t, oe, sr, vf, addr, st, e.oe, e.sr, e.vf, e.addr, e.st);
      end
    end
  end

  // m: [0] illegal op, [1] STOP with option off, [2] opcode fetch unmapped,
  //    [3] watchdog, [4] bus reset; ext drives the pad low from outside
  task automatic fire(logic [4:0] m, logic ext, string tag);
    @(negedge clk);
    illegal_op = m[0]; stop_exec = m[1]; stop_en = ~m[1];
    unmapped = m[2]; opfetch = m[2]; cop = m[3]; bus = m[4]; ext_low = ext;
    if (m[0] || m[1]) exp_st[3] = 1'b1;
    if (m[2]) exp_st[4] = 1'b1;
    if (m[3]) exp_st[2] = 1'b1;
    if (m[4]) exp_st[5] = 1'b1;
    if (ext && m == 5'd0) exp_st[1] = 1'b1;
    push_seq(tag);
    @(negedge clk);
    illegal_op = 0; stop_exec = 0; stop_en = 1; unmapped = 0; opfetch = 0;
    cop = 0; bus = 0; ext_low = 0;
    wait (q.size() == 0);
  endtask

  task automatic check1(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_st = 6'b000001;
    repeat (3) @(negedge clk);
    // R1 reset state
    check1(oe, 1'b1, "R1 oe under por");
    check1(sr, 1'b1, "R1 sys_rst under por");
    check1(st == 6'b000001, 1'b1, "R1 status under por");
    @(negedge clk);
    por = 1'b0;
    push(1, 1, 0, 16'h0, "R1 hold", POR - 1);
    push_seq("R1 R2 R11 power-on sequence");
    wait (q.size() == 0);

    fire(5'b00001, 1'b0, "R3 R11 illegal opcode");
    fire(5'b00010, 1'b0, "R4 stop trapped");

    // R4: STOP allowed, no effect
    @(negedge clk);
    stop_exec = 1; stop_en = 1;
    push(0, 0, 0, 16'h0, "R4 stop allowed", 3);
    @(negedge clk);
    stop_exec = 0;
    wait (q.size() == 0);

    fire(5'b00100, 1'b0, "R5 opcode fetch unmapped");

    // R5: data access to unmapped address, no effect
    @(negedge clk);
    unmapped = 1; opfetch = 0;
    push(0, 0, 0, 16'h0, "R5 data access", 3);
    @(negedge clk);
    unmapped = 0;
    wait (q.size() == 0);

    // R7: outside low together with a watchdog timeout -> pad bit stays clear
    fire(5'b01000, 1'b1, "R6 R7 watchdog with pad low");
    fire(5'b10000, 1'b0, "R6 bus reset");

    // R9: restart in the middle of the drive phase
    @(negedge clk);
    cop = 1;
    push(1, 1, 0, 16'h0, "R9 first drive", 20);
    @(negedge clk);
    cop = 0;
    wait (q.size() == 0);
    fire(5'b10000, 1'b0, "R9 restart in drive");

    // R9: restart in the release phase
    @(negedge clk);
    illegal_op = 1;
    push(1, 1, 0, 16'h0, "R9 drive", PH);
    push(0, 1, 0, 16'h0, "R9 release", 10);
    @(negedge clk);
    illegal_op = 0;
    wait (q.size() == 0);
    fire(5'b00100, 1'b0, "R9 restart in release");

    // R7: pure outside low on the pad
    fire(5'b00000, 1'b1, "R7 outside pad low");

    // R8: two causes in one cycle, both set, stays sticky
    fire(5'b01001, 1'b0, "R8 simultaneous causes");

    // R10: watchdog disable gate, every combination
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      mon = v[0]; brk = v[1]; hvr = v[2]; hvi = v[3];
      #1;
      check1(cop_dis, (v[0] & (v[2] | v[3])) | (v[1] & v[2]), "R10 cop disable");
    end
    @(negedge clk);
    mon = 0; brk = 0; hvr = 0; hvi = 0;

    // R8/R1: power-on clears everything but the power-on bit
    por = 1'b1;
    #1;
    check1(st == 6'b000001, 1'b1, "R8 power-on clears status");
    check1(oe, 1'b1, "R1 pad driven on power-on");
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule